// File: doc/BRIEF.md
# Firmware Image Loader Sequencer

This block is the host-side engine that hands a firmware image to a controller. The two sides share a staging window and a small mailbox of three 32-bit words: a status word, a flag owned by the controller, and a flag owned by the host. The sequencer sends a prepare command and zeroes the mailbox. It then has the image header placed in the staging window and sends a launch command. After that it streams the image in 128 KB chunks. Chunks alternate between a lower half and an upper half, and the host flag and the controller flag toggle back and forth between them. At every step the sequencer checks the status word for an ASCII progress code.

The bulk copy engine is reached through a request/acknowledge pair that carries a source address and a byte count. Commands and mailbox accesses each use their own request/acknowledge port. A single `start` pulse runs a whole transfer. At the end, `done` pulses for one cycle and `result` reports success, failure or timeout. The delay between status polls, the settling delay after a recognised code, and the timeout for every polling wait are run-time inputs.

Top module: `fwx_image_loader`

## Requirements
- R1: After `start`, the block issues command 0x10FE. It then writes zero to mailbox selects 0 (status), 1 (controller flag) and 2 (host flag), in that order. Next it requests a 2048-byte copy from `img_base`, and then issues command 0x20FE.
- R2: After the launch command, the block polls select 1 until it reads 1. It then polls select 0 until it reads 0x54784C4F (lower-half code). After that match, at least `settle_gap`+1 cycles pass before the next mailbox request.
- R3: After a poll that misses, at least `poll_gap`+1 cycles pass before the next read request starts.
- R4: Each pass runs these steps in order:
  - a 131072-byte copy;
  - a write of 1 to select 2;
  - a wait until select 1 is not 1;
  - a status check;
  - a wait for 0x54784849 (upper-half code), followed by a settle and a recheck;
  - a second 131072-byte copy;
  - a write of 0 to select 2;
  - a wait until select 1 is nonzero.
- R5: The copy source address starts at `img_base`. It advances by 2048 after the header copy and by 131072 after each chunk copy.
- R6: If the status reads 0x4241444E after a flag handshake, no further copy is requested and the run ends with result 2.
- R7: If the status reads the lower-half code after the upper half, another pass starts. At most 5 extra passes (6 in total) are made. After the 6th pass the run ends, and the result is 2 unless the final status is the completion code.
- R8: Result codes:
  - 0 after reset, and again after each accepted start;
  - 1 when the final status read equals 0x444F4E45;
  - 2 for any other final status.

  `done` is a one-cycle pulse, and `result` holds its value until the next start.
- R9: A polling wait that stays unsatisfied for `wait_limit` cycles ends the run. `done` pulses `wait_limit`+2 cycles after the launch command is acknowledged, with result 3.
- R10: A `start` pulse while `busy` is high is ignored. It does not change the command, copy or mailbox trace.
- R11: At most one of `cmd_req`, `mb_req` and `cp_req` is high at a time. A request stays high with stable fields until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a transfer when idle |
| img_base | input | AW | Source address of the image header |
| poll_gap | input | GW | Idle cycles after a missed poll |
| settle_gap | input | GW | Idle cycles after a recognised half code |
| wait_limit | input | TW | Cycle limit of each polling wait |
| cmd_req | output | 1 | Command request |
| cmd_code | output | 16 | Command word |
| cmd_ack | input | 1 | Command accepted |
| mb_req | output | 1 | Mailbox access request |
| mb_wr | output | 1 | 1 = write, 0 = read |
| mb_sel | output | 2 | 0 status, 1 controller flag, 2 host flag |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid with `mb_ack` |
| mb_ack | input | 1 | Mailbox access complete |
| cp_req | output | 1 | Chunk copy request |
| cp_addr | output | AW | Copy source address |
| cp_bytes | output | LEN_W | Copy length in bytes |
| cp_ack | input | 1 | Copy complete |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 none, 1 success, 2 failure, 3 timeout |
| busy | output | 1 | A transfer is in progress |

## Verification
Some properties are checked on every cycle:
- the request ports are exclusive and hold steady while waiting (R11);
- the gap and settle delays cannot be left early;
- an expired wait goes straight to a timeout result;
- a bad-storage status goes straight to the final read;
- the retry count stays bounded;
- `done` is a single-cycle pulse.

Other behaviours only the scenarios can show. These are the complete ordered trace of commands, mailbox writes and copy addresses, the number of passes before the retry bound, the final success or failure, and the timeout latency measured from the launch command. Against a reactive controller model, the scenarios also show that a mid-run `start` leaves the trace untouched.

// File: rtl/fwx_pkg.sv
package fwx_pkg;

    localparam logic [15:0] CMD_READY = 16'h10FE;
    localparam logic [15:0] CMD_GO    = 16'h20FE;

    localparam logic [31:0] CODE_LOW  = 32'h5478_4C4F;
    localparam logic [31:0] CODE_HIGH = 32'h5478_4849;
    localparam logic [31:0] CODE_BAD  = 32'h4241_444E;
    localparam logic [31:0] CODE_DONE = 32'h444F_4E45;

    typedef enum logic [1:0] {
        MB_STATUS = 2'd0,
        MB_CFLAG  = 2'd1,
        MB_HFLAG  = 2'd2
    } mb_sel_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_OK      = 2'd1,
        RES_FAIL    = 2'd2,
        RES_TIMEOUT = 2'd3
    } result_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CMD_READY,
        ST_CLR_STAT,
        ST_CLR_CFLG,
        ST_CLR_HFLG,
        ST_COPY_HDR,
        ST_CMD_GO,
        ST_POLL_CF_SET,
        ST_POLL_LOW,
        ST_CHK_RETRY,
        ST_COPY_LOW,
        ST_SET_HF1,
        ST_POLL_CF_CLR,
        ST_CHK_BAD,
        ST_POLL_HIGH,
        ST_CHK_HIGH,
        ST_COPY_HIGH,
        ST_SET_HF0,
        ST_POLL_CF_NZ,
        ST_CHK_END,
        ST_GAP,
        ST_SETTLE,
        ST_FINAL,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic        req;
        logic        wr;
        mb_sel_e     sel;
        logic [31:0] wdata;
    } mb_op_t;

    // Mailbox access implied by a sequencer state.
    function automatic mb_op_t mb_op_of(seq_state_e s);
        mb_op_t o;
        o.req   = 1'b1;
        o.wr    = 1'b0;
        o.sel   = MB_STATUS;
        o.wdata = 32'd0;
        case (s)
            ST_CLR_STAT: o.wr = 1'b1;
            ST_CLR_CFLG: begin o.wr = 1'b1; o.sel = MB_CFLAG; end
            ST_CLR_HFLG: begin o.wr = 1'b1; o.sel = MB_HFLAG; end
            ST_SET_HF1:  begin o.wr = 1'b1; o.sel = MB_HFLAG; o.wdata = 32'd1; end
            ST_SET_HF0:  begin o.wr = 1'b1; o.sel = MB_HFLAG; end
            ST_POLL_CF_SET, ST_POLL_CF_CLR, ST_POLL_CF_NZ: o.sel = MB_CFLAG;
            ST_POLL_LOW, ST_POLL_HIGH, ST_CHK_RETRY, ST_CHK_BAD,
            ST_CHK_HIGH, ST_CHK_END, ST_FINAL: o.sel = MB_STATUS;
            default: o.req = 1'b0;
        endcase
        return o;
    endfunction

    function automatic logic is_poll(seq_state_e s);
        return (s == ST_POLL_CF_SET) || (s == ST_POLL_LOW) || (s == ST_POLL_CF_CLR) ||
               (s == ST_POLL_HIGH) || (s == ST_POLL_CF_NZ);
    endfunction

    // Condition that ends a polling wait.
    function automatic logic poll_hit(seq_state_e s, logic [31:0] v);
        case (s)
            ST_POLL_CF_SET: return v == 32'd1;
            ST_POLL_LOW:    return v == CODE_LOW;
            ST_POLL_CF_CLR: return v != 32'd1;
            ST_POLL_HIGH:   return v == CODE_HIGH;
            ST_POLL_CF_NZ:  return v != 32'd0;
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fwx_gap_timer.sv
module fwx_gap_timer #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    output logic          zero
);
    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fwx_wait_guard.sv
module fwx_wait_guard #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || clear) cnt <= '0;
        else if (cnt < limit)     cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt >= limit);
endmodule

// File: rtl/fwx_src_addr.sv
module fwx_src_addr #(
    parameter int AW    = 32,
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [AW-1:0]    base,
    input  logic             step,
    input  logic [LEN_W-1:0] step_bytes,
    output logic [AW-1:0]    addr
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= base;
        else if (step) addr <= addr + AW'(step_bytes);
    end
endmodule

// File: rtl/fwx_image_loader.sv
module fwx_image_loader
    import fwx_pkg::*;
#(
    parameter int AW          = 32,
    parameter int GW          = 16,
    parameter int TW          = 20,
    parameter int HDR_BYTES   = 2048,
    parameter int CHUNK_BYTES = 131072,
    parameter int MAX_RETRY   = 5,
    parameter int LEN_W       = $clog2(CHUNK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    img_base,
    input  logic [GW-1:0]    poll_gap,
    input  logic [GW-1:0]    settle_gap,
    input  logic [TW-1:0]    wait_limit,
    output logic             cmd_req,
    output logic [15:0]      cmd_code,
    input  logic             cmd_ack,
    output logic             mb_req,
    output logic             mb_wr,
    output logic [1:0]       mb_sel,
    output logic [31:0]      mb_wdata,
    input  logic [31:0]      mb_rdata,
    input  logic             mb_ack,
    output logic             cp_req,
    output logic [AW-1:0]    cp_addr,
    output logic [LEN_W-1:0] cp_bytes,
    input  logic             cp_ack,
    output logic             done,
    output logic [1:0]       result,
    output logic             busy
);
    localparam int RW = $clog2(MAX_RETRY + 1);

    seq_state_e    state, state_n, ret, ret_n;
    logic [RW-1:0] retry, retry_n;
    result_e       res, res_n;
    mb_op_t        op;
    logic          tmr_load, tmr_zero;
    logic [GW-1:0] tmr_val;
    logic          in_wait, wd_clear, wd_expired;
    logic          accept;

    assign op       = mb_op_of(state);
    assign in_wait  = is_poll(state) || (state == ST_GAP);
    assign wd_clear = is_poll(state) && mb_ack && poll_hit(state, mb_rdata);
    assign accept   = (state == ST_IDLE) && start;

    fwx_gap_timer #(.GW(GW)) u_gap (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    fwx_wait_guard #(.TW(TW)) u_guard (
        .clk(clk), .rst(rst), .run(in_wait), .clear(wd_clear),
        .limit(wait_limit), .expired(wd_expired)
    );

    fwx_src_addr #(.AW(AW), .LEN_W(LEN_W)) u_addr (
        .clk(clk), .rst(rst), .load(accept), .base(img_base),
        .step(cp_req && cp_ack), .step_bytes(cp_bytes), .addr(cp_addr)
    );

    always_comb begin
        state_n  = state;
        ret_n    = ret;
        retry_n  = retry;
        res_n    = res;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (start) begin
                state_n = ST_CMD_READY;
                retry_n = '0;
                res_n   = RES_NONE;
            end
            ST_CMD_READY: if (cmd_ack) state_n = ST_CLR_STAT;
            ST_CLR_STAT:  if (mb_ack)  state_n = ST_CLR_CFLG;
            ST_CLR_CFLG:  if (mb_ack)  state_n = ST_CLR_HFLG;
            ST_CLR_HFLG:  if (mb_ack)  state_n = ST_COPY_HDR;
            ST_COPY_HDR:  if (cp_ack)  state_n = ST_CMD_GO;
            ST_CMD_GO:    if (cmd_ack) state_n = ST_POLL_CF_SET;
            ST_POLL_CF_SET, ST_POLL_LOW, ST_POLL_CF_CLR, ST_POLL_HIGH, ST_POLL_CF_NZ: begin
                if (wd_expired) begin
                    state_n = ST_DONE;
                    res_n   = RES_TIMEOUT;
                end else if (mb_ack) begin
                    if (poll_hit(state, mb_rdata)) begin
                        case (state)
                            ST_POLL_CF_SET: state_n = ST_POLL_LOW;
                            ST_POLL_LOW: begin
                                state_n  = ST_SETTLE;
                                ret_n    = ST_CHK_RETRY;
                                tmr_load = 1'b1;
                                tmr_val  = settle_gap;
                            end
                            ST_POLL_CF_CLR: state_n = ST_CHK_BAD;
                            ST_POLL_HIGH: begin
                                state_n  = ST_SETTLE;
                                ret_n    = ST_CHK_HIGH;
                                tmr_load = 1'b1;
                                tmr_val  = settle_gap;
                            end
                            default: state_n = ST_CHK_END;
                        endcase
                    end else begin
                        state_n  = ST_GAP;
                        ret_n    = state;
                        tmr_load = 1'b1;
                        tmr_val  = poll_gap;
                    end
                end
            end
            ST_GAP: begin
                if (wd_expired) begin
                    state_n = ST_DONE;
                    res_n   = RES_TIMEOUT;
                end else if (tmr_zero) begin
                    state_n = ret;
                end
            end
            ST_SETTLE: if (tmr_zero) state_n = ret;
            ST_CHK_RETRY: if (mb_ack)
                state_n = (mb_rdata == CODE_LOW) ? ST_COPY_LOW : ST_FINAL;
            ST_COPY_LOW:  if (cp_ack) state_n = ST_SET_HF1;
            ST_SET_HF1:   if (mb_ack) state_n = ST_POLL_CF_CLR;
            ST_CHK_BAD:   if (mb_ack)
                state_n = (mb_rdata == CODE_BAD) ? ST_FINAL : ST_POLL_HIGH;
            ST_CHK_HIGH:  if (mb_ack)
                state_n = (mb_rdata == CODE_HIGH) ? ST_COPY_HIGH : ST_FINAL;
            ST_COPY_HIGH: if (cp_ack) state_n = ST_SET_HF0;
            ST_SET_HF0:   if (mb_ack) state_n = ST_POLL_CF_NZ;
            ST_CHK_END: if (mb_ack) begin
                if (mb_rdata == CODE_LOW && retry < RW'(MAX_RETRY)) begin
                    retry_n = retry + 1'b1;
                    state_n = ST_CHK_RETRY;
                end else begin
                    state_n = ST_FINAL;
                end
            end
            ST_FINAL: if (mb_ack) begin
                res_n   = (mb_rdata == CODE_DONE) ? RES_OK : RES_FAIL;
                state_n = ST_DONE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ret   <= ST_IDLE;
            retry <= '0;
            res   <= RES_NONE;
        end else begin
            state <= state_n;
            ret   <= ret_n;
            retry <= retry_n;
            res   <= res_n;
        end
    end

    assign cmd_req  = (state == ST_CMD_READY) || (state == ST_CMD_GO);
    assign cmd_code = (state == ST_CMD_READY) ? CMD_READY : CMD_GO;
    assign mb_req   = op.req;
    assign mb_wr    = op.wr;
    assign mb_sel   = op.sel;
    assign mb_wdata = op.wdata;
    assign cp_req   = (state == ST_COPY_HDR) || (state == ST_COPY_LOW) || (state == ST_COPY_HIGH);
    assign cp_bytes = (state == ST_COPY_HDR) ? LEN_W'(HDR_BYTES) : LEN_W'(CHUNK_BYTES);
    assign done     = (state == ST_DONE);
    assign result   = res;
    assign busy     = (state != ST_IDLE);

    // R11: ports are exclusive and requests hold until acknowledged
    a_r11_one_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_req, mb_req, cp_req}));
    a_r11_cp_hold: assert property (@(posedge clk) disable iff (rst)
        (cp_req && !cp_ack) |=> (cp_req && $stable(cp_addr) && $stable(cp_bytes)));
    a_r11_mb_hold: assert property (@(posedge clk) disable iff (rst)
        (mb_req && !mb_ack && !(in_wait && wd_expired)) |=>
            (mb_req && $stable(mb_sel) && $stable(mb_wr) && $stable(mb_wdata)));
    // R3: poll gap is not cut short
    a_r3_gap_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && !tmr_zero && !wd_expired) |=> (state == ST_GAP));
    // R2: settle delay is not cut short
    a_r2_settle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE && !tmr_zero) |=> (state == ST_SETTLE && !mb_req));
    // R6: bad-storage status leads to the final read
    a_r6_bad_abort: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHK_BAD && mb_ack && mb_rdata == CODE_BAD) |=> (state == ST_FINAL));
    // R7: pass count bounded
    a_r7_retry_bound: assert property (@(posedge clk) disable iff (rst)
        retry <= RW'(MAX_RETRY));
    // R8: done is a single pulse carrying a result
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_result: assert property (@(posedge clk) disable iff (rst)
        done |-> (result != RES_NONE));
    // R9: expiry ends the run with timeout
    a_r9_timeout: assert property (@(posedge clk) disable iff (rst)
        (in_wait && wd_expired) |=> (done && result == RES_TIMEOUT));
    // R10: start during a run leaves the copy address alone
    a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(cp_req && cp_ack)) |=> $stable(cp_addr));

endmodule

// File: tb/sim_fwx_image_loader.sv
`timescale 1ns/1ps
module sim_fwx_image_loader;
    import fwx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] img_base = '0;
    logic [15:0] poll_gap = 16'd4;
    logic [15:0] settle_gap = 16'd9;
    logic [19:0] wait_limit = 20'd2000;
    logic        cmd_req, cmd_ack;
    logic [15:0] cmd_code;
    logic        mb_req, mb_wr, mb_ack;
    logic [1:0]  mb_sel;
    logic [31:0] mb_wdata, mb_rdata;
    logic        cp_req, cp_ack;
    logic [31:0] cp_addr;
    logic [17:0] cp_bytes;
    logic        done, busy;
    logic [1:0]  result;

    always #2 clk = ~clk;

    fwx_image_loader u0 (
        .clk(clk), .rst(rst), .start(start), .img_base(img_base),
        .poll_gap(poll_gap), .settle_gap(settle_gap), .wait_limit(wait_limit),
        .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_ack(cmd_ack),
        .mb_req(mb_req), .mb_wr(mb_wr), .mb_sel(mb_sel), .mb_wdata(mb_wdata),
        .mb_rdata(mb_rdata), .mb_ack(mb_ack),
        .cp_req(cp_req), .cp_addr(cp_addr), .cp_bytes(cp_bytes), .cp_ack(cp_ack),
        .done(done), .result(result), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // ---------------- controller model ----------------
    logic [31:0] m_stat, m_cf, m_hf;
    bit  armed;
    int  pass_n, pend, pend_kind;
    int  cfg_loops = 0;
    int  cfg_bad = -1;
    bit  cfg_mute = 1'b0;

    always @(posedge clk) begin
        cyc    <= cyc + 1;
        mb_ack <= 1'b0;
        cmd_ack <= 1'b0;
        cp_ack <= 1'b0;
        if (rst) begin
            m_stat <= '0; m_cf <= '0; m_hf <= '0;
            armed <= 1'b0; pass_n <= 0; pend <= 0; pend_kind <= 0; mb_rdata <= '0;
        end else begin
            if (pend > 1) pend <= pend - 1;
            else if (pend == 1) begin
                pend <= 0;
                case (pend_kind)
                    0: begin m_cf <= 32'd1; m_stat <= CODE_LOW; end
                    1: begin m_cf <= 32'd0; m_stat <= (pass_n == cfg_bad) ? CODE_BAD : CODE_HIGH; end
                    default: begin
                        m_cf <= 32'd1;
                        m_stat <= (pass_n < cfg_loops) ? CODE_LOW : CODE_DONE;
                        pass_n <= pass_n + 1;
                    end
                endcase
            end
            if (start && !busy) begin armed <= 1'b0; pass_n <= 0; pend <= 0; end
            if (cmd_req && !cmd_ack) begin
                cmd_ack <= 1'b1;
                if (cmd_code == CMD_GO && !cfg_mute) begin armed <= 1'b1; pend <= 7; pend_kind <= 0; end
            end
            if (cp_req && !cp_ack) cp_ack <= 1'b1;
            if (mb_req && !mb_ack) begin
                mb_ack <= 1'b1;
                case (mb_sel)
                    2'd0: mb_rdata <= m_stat;
                    2'd1: mb_rdata <= m_cf;
                    default: mb_rdata <= m_hf;
                endcase
                if (mb_wr) begin
                    case (mb_sel)
                        2'd0: m_stat <= mb_wdata;
                        2'd1: m_cf <= mb_wdata;
                        default: begin
                            m_hf <= mb_wdata;
                            if (armed) begin pend <= 5; pend_kind <= (mb_wdata == 32'd1) ? 1 : 2; end
                        end
                    endcase
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int          kind;   // 0 cmd, 1 copy, 2 mailbox write, 3 result
        logic [31:0] a;
        logic [31:0] b;
        string       rq;
    } item_t;
    item_t expq[$];

    task automatic push(int kind, logic [31:0] a, logic [31:0] b, string rq);
        item_t it;
        it.kind = kind; it.a = a; it.b = b; it.rq = rq;
        expq.push_back(it);
    endtask

    task automatic take(int kind, logic [31:0] a, logic [31:0] b);
        item_t it;
        if (expq.size() == 0) begin
            chk(1'b0, "R10", "unexpected transaction kind", 32'(kind), 32'hFFFF_FFFF);
        end else begin
            it = expq.pop_front();
            chk(it.kind == kind, it.rq, "transaction kind", 32'(kind), 32'(it.kind));
            chk(it.a == a, it.rq, "field a", a, it.a);
            chk(it.b == b, it.rq, "field b", b, it.b);
        end
    endtask

    bit   mb_prev = 1'b0;
    bit   gap_mode = 1'b0;
    bit   settle_armed = 1'b0;
    int   settle_mark = -1;
    int   last_rd = -1;
    int   go_cyc = 0;
    int   done_cyc = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_req && cmd_ack) begin
                take(0, 32'(cmd_code), 32'd0);
                if (cmd_code == CMD_GO) begin settle_armed = 1'b1; go_cyc = cyc; end
            end
            if (cp_req && cp_ack) take(1, cp_addr, 32'(cp_bytes));
            if (mb_req && mb_ack && mb_wr) take(2, 32'(mb_sel), mb_wdata);
            if (done) begin take(3, 32'(result), 32'd0); done_cyc = cyc; end
            if (mb_req && mb_ack && !mb_wr && mb_sel == 2'd0 && mb_rdata == CODE_LOW && settle_armed) begin
                settle_mark = cyc;
                settle_armed = 1'b0;
            end
            if (mb_req && !mb_prev) begin
                if (settle_mark >= 0) begin
                    // R2: settle delay after the lower-half code
                    chk((cyc - settle_mark) >= int'(settle_gap) + 1, "R2", "settle spacing",
                        32'(cyc - settle_mark), 32'(settle_gap + 1));
                    settle_mark = -1;
                end
                if (gap_mode && !mb_wr && last_rd >= 0)
                    // R3: spacing between missed polls
                    chk((cyc - last_rd) >= int'(poll_gap) + 1, "R3", "poll spacing",
                        32'(cyc - last_rd), 32'(poll_gap + 1));
                if (!mb_wr) last_rd = cyc;
            end
            mb_prev = mb_req;
        end
    end

    // ---------------- scenarios ----------------
    task automatic build(logic [31:0] base, int loops, int bad, bit mute);
        logic [31:0] addr;
        expq.delete();
        // R1: opening sequence
        push(0, 32'(CMD_READY), 0, "R1");
        push(2, 32'd0, 32'd0, "R1");
        push(2, 32'd1, 32'd0, "R1");
        push(2, 32'd2, 32'd0, "R1");
        push(1, base, 32'd2048, "R5");
        push(0, 32'(CMD_GO), 0, "R1");
        addr = base + 32'd2048;
        if (mute) begin
            push(3, 32'(RES_TIMEOUT), 0, "R9");
        end else begin
            for (int p = 0; p < 6; p++) begin
                push(1, addr, 32'd131072, "R5"); addr += 32'd131072;
                push(2, 32'd2, 32'd1, "R4");
                if (p == bad) begin push(3, 32'(RES_FAIL), 0, "R6"); break; end
                push(1, addr, 32'd131072, "R4"); addr += 32'd131072;
                push(2, 32'd2, 32'd0, "R4");
                if (p >= loops) begin push(3, 32'(RES_OK), 0, "R8"); break; end
                if (p == 5) begin push(3, 32'(RES_FAIL), 0, "R7"); break; end
            end
        end
    endtask

    task automatic run_case(logic [31:0] base, int loops, int bad, bit mute, bit poke, logic [1:0] exp_res);
        @(negedge clk);
        cfg_loops = loops; cfg_bad = bad; cfg_mute = mute;
        gap_mode = mute; last_rd = -1; settle_mark = -1; settle_armed = 1'b0;
        build(base, loops, bad, mute);
        img_base = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: result cleared once a run is accepted
        chk(result == 2'd0, "R8", "result cleared at start", 32'(result), 32'd0);
        if (poke) begin
            repeat (60) @(negedge clk);
            img_base = 32'hDEAD_0000; start = 1'b1;   // R10: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(expq.size() == 0, poke ? "R10" : "R4", "trace fully consumed", 32'(expq.size()), 32'd0);
        chk(result == exp_res, "R8", "result held after done", 32'(result), 32'(exp_res));
        chk(!busy, "R8", "idle after done", 32'(busy), 32'd0);
        if (mute) begin
            // R9: timeout latency from launch command
            chk((done_cyc - go_cyc) == int'(wait_limit) + 2, "R9", "timeout latency",
                32'(done_cyc - go_cyc), 32'(wait_limit + 2));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 and R11: reset state
        chk(!busy && !done, "R8", "idle after reset", 32'({busy, done}), 32'd0);
        chk(result == 2'd0, "R8", "result after reset", 32'(result), 32'd0);
        chk(!cmd_req && !mb_req && !cp_req, "R11", "no request after reset",
            32'({cmd_req, mb_req, cp_req}), 32'd0);

        run_case(32'h1000_0000, 0, -1, 1'b0, 1'b0, 2'd1);   // single pass, success
        run_case(32'h2000_0800, 2, -1, 1'b0, 1'b1, 2'd1);   // three passes, start poked mid-run
        run_case(32'h3000_0000, 7, -1, 1'b0, 1'b0, 2'd2);   // R7 pass bound reached
        run_case(32'h4000_0000, 3, 1, 1'b0, 1'b0, 2'd2);    // R6 bad storage in pass 1
        poll_gap = 16'd12; wait_limit = 20'd300;
        run_case(32'h5000_0000, 0, -1, 1'b1, 1'b0, 2'd3);   // R9 silent controller
        poll_gap = 16'd4; wait_limit = 20'd2000;
        run_case(32'h6000_0000, 0, 0, 1'b0, 1'b0, 2'd2);    // R6 bad storage in first pass

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule